// File: doc/BRIEF.md
# Per-Channel DMA Completion Interrupt Router

This block gathers completion and fault events from a set of DMA channels and turns them into interrupt requests. Each channel has a dedicated transmit line and a dedicated receive line. All channels also share one common line. Every event is latched into a sticky status bit that software clears by writing 1. Separate enables decide which latched bits may drive interrupts.

A single mode bit selects how completions are reported. In shared mode, an enabled transmit or receive completion raises its dedicated line and also the common line, and it shows in a per-channel summary bit. In split mode, completions raise only their dedicated lines, which suits one interrupt vector per channel and direction. The common line and the summary bit then carry nothing from completions. Fault (abnormal) events reach the common line in both modes.

Software uses a small register port with a write strobe and a combinational read. The address holds a channel index in its upper bits and a 2-bit selector in its low bits. Selector 0 is channel status, 1 is channel enables, 2 reads as zero and 3 is global control. A view field in the control register hides the transmit or the receive status bits on read-back.

Top module: `dma_irq_router`

## Requirements
- R1: After reset, all status bits, enables, the mode bit and the view field are 0, and every interrupt output is low.
- R2: A high tx_done, rx_done or abn_evt input for channel c during a clock edge sets that channel's sticky TX bit, RX bit or fault bit. The bit stays set until it is cleared.
- R3: A write to address {c, 2'b00} clears each status bit of channel c whose data bit is 1 (bit 0 TX, bit 1 RX, bit 2 fault). Bits written 0 keep their value. An event arriving in the same cycle as the clear leaves the bit set.
- R4: tx_irq[c] is high exactly when the TX status bit and the TX enable of channel c are both set. rx_irq[c] behaves the same way with the RX bit and RX enable. The two enables act independently.
- R5: When the mode bit is 0, any enabled TX or RX status bit of any channel drives common_irq high.
- R6: When the mode bit is 1, TX and RX status bits have no effect on common_irq.
- R7: Bit 3 of a status read is the summary bit. In mode 0 it is the OR of the enabled TX and RX bits visible in that read. In mode 1 it is always 0.
- R8: The control register is at selector 3 and ignores the channel field. Bit 0 is mode. Bits 2:1 are the view: 0 or 3 shows TX and RX, 1 shows RX only (TX reads 0), 2 shows TX only (RX reads 0). Reset gives view 0.
- R9: An enabled fault status bit of any channel drives common_irq high in either mode.
- R10: A write to address {c, 2'b01} loads the enables of channel c (bit 0 TX, bit 1 RX, bit 2 fault). A read of that address returns them. Selector 2 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | NCH | Per-channel transmit completion events |
| rx_done | input | NCH | Per-channel receive completion events |
| abn_evt | input | NCH | Per-channel fault events |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | CW+2 | Register address {channel, selector} |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| tx_irq | output | NCH | Per-channel transmit interrupt lines |
| rx_irq | output | NCH | Per-channel receive interrupt lines |
| common_irq | output | 1 | Shared interrupt line |

## Verification
The bench drives a clear and a new event into the same bit in the same cycle. A design that let the clear win would lose that event. It switches to split mode while completions are pending and enabled; a design still ORing them into the common line, or still raising the summary bit, is caught at common_irq and at status bit 3. It also masks one direction while the other fires, which catches crossed enables, and reads status under each view setting, which catches a read-back mask applied to the wrong direction. A long random run then checks every output and a random register read against a bench model after each cycle.

// File: rtl/dma_irq_router.sv
module dma_irq_router #(
  parameter int NCH = 4,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   tx_done,
  input  logic [NCH-1:0]   rx_done,
  input  logic [NCH-1:0]   abn_evt,
  input  logic             reg_wen,
  input  logic [CW+1:0]    reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic [NCH-1:0]   tx_irq,
  output logic [NCH-1:0]   rx_irq,
  output logic             common_irq
);
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_EN   = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  logic [NCH-1:0] ti, ri, ai, tie, rie, aie;
  logic           mode;
  logic [1:0]     view;
  logic           unused_wd;

  assign unused_wd = ^reg_wdata[7:3];

  wire [1:0]    sel = reg_addr[1:0];
  wire [CW-1:0] ach = reg_addr[CW+1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= 1'b0;
      view <= 2'd0;
    end else if (reg_wen && sel == SEL_CTRL) begin
      mode <= reg_wdata[0];
      view <= reg_wdata[2:1];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ti_q, ri_q, ai_q, tie_q, rie_q, aie_q;
    wire  hit  = reg_wen && (ach == CW'(c));
    wire  wst  = hit && (sel == SEL_STAT);
    wire  wen  = hit && (sel == SEL_EN);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ti_q <= 1'b0; ri_q <= 1'b0; ai_q <= 1'b0;
        tie_q <= 1'b0; rie_q <= 1'b0; aie_q <= 1'b0;
      end else begin
        ti_q <= tx_done[c] | (ti_q & ~(wst & reg_wdata[0]));
        ri_q <= rx_done[c] | (ri_q & ~(wst & reg_wdata[1]));
        ai_q <= abn_evt[c] | (ai_q & ~(wst & reg_wdata[2]));
        if (wen) begin
          tie_q <= reg_wdata[0];
          rie_q <= reg_wdata[1];
          aie_q <= reg_wdata[2];
        end
      end
    end

    assign ti[c]  = ti_q;
    assign ri[c]  = ri_q;
    assign ai[c]  = ai_q;
    assign tie[c] = tie_q;
    assign rie[c] = rie_q;
    assign aie[c] = aie_q;
  end

  assign tx_irq = ti & tie;
  assign rx_irq = ri & rie;
  assign common_irq = (|(ai & aie)) | (~mode & (|(tx_irq | rx_irq)));

  always_comb begin
    logic tiv, riv;
    reg_rdata = 8'd0;
    tiv = 1'b0;
    riv = 1'b0;
    if (int'(ach) < NCH) begin
      tiv = ti[ach] & (view != 2'd1);
      riv = ri[ach] & (view != 2'd2);
    end
    case (sel)
      SEL_STAT: if (int'(ach) < NCH)
        reg_rdata[3:0] = {~mode & ((tiv & tie[ach]) | (riv & rie[ach])),
                          ai[ach], riv, tiv};
      SEL_EN:   if (int'(ach) < NCH)
        reg_rdata[2:0] = {aie[ach], rie[ach], tie[ach]};
      SEL_CTRL: reg_rdata[2:0] = {view, mode};
      default:  reg_rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NCH = 4,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] tx_done,
  input logic           reg_wen,
  input logic [CW+1:0]  reg_addr,
  input logic           clr_tx,
  input logic [NCH-1:0] tx_irq,
  input logic           common_irq,
  input logic           mode,
  input logic [NCH-1:0] ti,
  input logic [NCH-1:0] tie,
  input logic [NCH-1:0] ai,
  input logic [NCH-1:0] aie
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    p_tx_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done[c] |=> ti[c]);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == {CW'(c), 2'd0} && clr_tx && !tx_done[c]) |=> !ti[c]);
    p_line_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq[c] |-> (ti[c] && tie[c]));
  end

  p_split_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && (ai & aie) == '0) |-> !common_irq);
  p_fault_common_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ai & aie)) |-> common_irq);
endmodule

bind dma_irq_router irq_router_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .reg_wen(reg_wen),
  .reg_addr(reg_addr), .clr_tx(reg_wdata[0]), .tx_irq(tx_irq),
  .common_irq(common_irq), .mode(mode), .ti(ti), .tie(tie),
  .ai(ai), .aie(aie)
);

// File: tb/test_dma_irq_router.sv
`timescale 1ns/1ps
module test_dma_irq_router;
  localparam int NCH = 4;
  localparam int CW  = 2;
  localparam int AW  = CW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] tx_done = '0, rx_done = '0, abn_evt = '0;
  logic reg_wen = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [NCH-1:0] tx_irq, rx_irq;
  logic common_irq;

  int n_chk = 0, n_fail = 0;
  logic [NCH-1:0] m_ti = '0, m_ri = '0, m_ai = '0, m_tie = '0, m_rie = '0, m_aie = '0;
  logic m_mode = 1'b0;
  logic [1:0] m_view = 2'd0;

  always #2.5 clk = ~clk;

  dma_irq_router #(.NCH(NCH)) i_dma_irq_router (
    .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .rx_done(rx_done),
    .abn_evt(abn_evt), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .common_irq(common_irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [AW-1:0] ad);
    logic [1:0] s = ad[1:0];
    int ch = int'(ad[AW-1:2]);
    logic tv, rv;
    exp_rd = 8'd0;
    if (s == 2'd3) exp_rd = {5'd0, m_view, m_mode};
    else if (ch < NCH && s == 2'd1) exp_rd = {5'd0, m_aie[ch], m_rie[ch], m_tie[ch]};
    else if (ch < NCH && s == 2'd0) begin
      tv = m_ti[ch] & (m_view != 2'd1);
      rv = m_ri[ch] & (m_view != 2'd2);
      exp_rd = {4'd0, ~m_mode & ((tv & m_tie[ch]) | (rv & m_rie[ch])), m_ai[ch], rv, tv};
    end
  endfunction

  task automatic model(input logic [NCH-1:0] t, r, a, input logic w,
                       input logic [AW-1:0] ad, input logic [7:0] d);
    for (int c = 0; c < NCH; c++) begin
      logic hit = w && int'(ad[AW-1:2]) == c;
      if (hit && ad[1:0] == 2'd0) begin
        if (d[0]) m_ti[c] = 1'b0;
        if (d[1]) m_ri[c] = 1'b0;
        if (d[2]) m_ai[c] = 1'b0;
      end
      if (hit && ad[1:0] == 2'd1) begin
        m_tie[c] = d[0]; m_rie[c] = d[1]; m_aie[c] = d[2];
      end
      if (t[c]) m_ti[c] = 1'b1;
      if (r[c]) m_ri[c] = 1'b1;
      if (a[c]) m_ai[c] = 1'b1;
    end
    if (w && ad[1:0] == 2'd3) begin
      m_mode = d[0];
      m_view = d[2:1];
    end
  endtask

  task automatic chk_lines(input string tag);
    logic ce;
    ce = (|(m_ai & m_aie)) | (~m_mode & (|((m_ti & m_tie) | (m_ri & m_rie))));
    check({tag, " R4 tx_irq"}, 32'(tx_irq), 32'(m_ti & m_tie));
    check({tag, " R4 rx_irq"}, 32'(rx_irq), 32'(m_ri & m_rie));
    check(m_mode ? {tag, " R6 common"} : {tag, " R5 common"}, 32'(common_irq), 32'(ce));
  endtask

  task automatic step(input logic [NCH-1:0] t, r, a, input logic w,
                      input logic [AW-1:0] ad, input logic [7:0] d);
    tx_done = t; rx_done = r; abn_evt = a;
    reg_wen = w; reg_addr = ad; reg_wdata = d;
    model(t, r, a, w, ad, d);
    @(posedge clk);
    @(negedge clk);
    tx_done = '0; rx_done = '0; abn_evt = '0; reg_wen = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] ad);
    reg_addr = ad;
    #1;
    check(tag, 32'(reg_rdata), 32'(exp_rd(ad)));
  endtask

  task automatic wr(input logic [AW-1:0] ad, input logic [7:0] d);
    step('0, '0, '0, 1'b1, ad, d);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    check("R1 tx_irq reset", 32'(tx_irq), 0);
    check("R1 rx_irq reset", 32'(rx_irq), 0);
    check("R1 common reset", 32'(common_irq), 0);
    rd("R1 ctrl reset", 4'b0011);
    rd("R1 status reset", 4'b0000);
    rd("R1 enable reset", 4'b0001);

    step(4'b0010, '0, '0, 1'b0, '0, '0);
    rd("R2 tx sticky set", 4'b0100);
    step('0, '0, '0, 1'b0, '0, '0);
    rd("R2 tx sticky held", 4'b0100);
    chk_lines("R4 disabled tx");

    wr(4'b0101, 8'h01);
    chk_lines("R4 tx enabled");
    step('0, 4'b0010, '0, 1'b0, '0, '0);
    chk_lines("R4 rx masked tx active");
    rd("R7 summary mode0", 4'b0100);
    rd("R10 enable readback", 4'b0101);
    rd("R10 selector2 zero", 4'b0110);

    step(4'b0010, '0, '0, 1'b1, 4'b0100, 8'h01);
    rd("R3 event beats clear", 4'b0100);
    wr(4'b0100, 8'h00);
    rd("R3 write zero keeps", 4'b0100);
    wr(4'b0100, 8'h02);
    rd("R3 clear rx only", 4'b0100);

    wr(4'b0011, 8'h01);
    chk_lines("R6 split mode");
    check("R6 common quiet", 32'(common_irq), 0);
    rd("R7 summary mode1", 4'b0100);
    step('0, '0, 4'b1000, 1'b0, '0, '0);
    wr(4'b1101, 8'h04);
    check("R9 fault in split mode", 32'(common_irq), 1);

    step('0, 4'b0010, '0, 1'b0, '0, '0);
    wr(4'b0011, 8'h02);
    rd("R8 view rx only", 4'b0100);
    wr(4'b0011, 8'h04);
    rd("R8 view tx only", 4'b0100);
    wr(4'b0011, 8'h06);
    rd("R8 view both", 4'b0100);
    wr(4'b1111, 8'h00);
    rd("R8 ctrl ignores channel", 4'b0011);
    check("R9 fault in shared mode", 32'(common_irq), 1);

    for (int i = 0; i < 4000; i++) begin
      logic [NCH-1:0] t, r, a;
      logic w;
      t = NCH'($urandom & $urandom);
      r = NCH'($urandom & $urandom);
      a = NCH'($urandom & $urandom & $urandom);
      w = ($urandom_range(0, 2) == 0);
      step(t, r, a, w, AW'($urandom), 8'($urandom_range(0, 7)));
      chk_lines("rand");
      rd("rand R2 R3 R7 R8 R10 read", AW'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule